// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block watches four modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect) and presents them to a CPU as one 8-bit status byte. The upper nibble gives the present level of each line. The lower nibble holds sticky flags that record a change on each line since the CPU last read the byte. A read strobe returns the byte and clears the flags. An interrupt request is raised while any flag is set and the modem-status interrupt enable is high.

External lines pass through a multi-stage synchronizer before they are compared. For diagnostics a loopback control disconnects the external lines. The four internal status lines are then taken from the modem control outputs, so that software can exercise every status bit without a cable. The mapping is: request-to-send to CTS, terminal-ready to DSR, user output 1 to RI, and user output 2 to DCD.

Top module: `mstat_reg`

## Requirements
- R1: While `rst` is high, the flags `rd_data[3:0]` are 0 and `irq` is 0. The level bits `rd_data[7:4]` keep following the selected inputs.
- R2: Level bits are `rd_data[4]`=CTS, `rd_data[5]`=DSR, `rd_data[6]`=RI and `rd_data[7]`=DCD. Outside loopback, a change on an external pin appears in its level bit after two rising clock edges.
- R3: Change flags are `rd_data[0]` for CTS, `rd_data[1]` for DSR and `rd_data[3]` for DCD. Each flag sets on either edge of its line, one clock edge after the level bit changes.
- R4: Flag `rd_data[2]` sets only on a low-to-high change of RI. A falling RI leaves it unchanged.
- R5: During a cycle with `rd_stb` high, `rd_data` shows the flags before clearing. The flags are 0 after that clock edge unless R6 applies.
- R6: A line change detected in the same cycle as a read sets its flag after the clear.
- R7: With `mcr_loop`=1, the external pins have no effect. CTS follows `mcr_rts`, DSR follows `mcr_dtr`, RI follows `mcr_out1` and DCD follows `mcr_out2`, in the same cycle.
- R8: `irq` is high exactly when `ien_modem` is 1 and at least one flag is set.
- R9: A set flag stays set until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_cts | input | 1 | External clear-to-send level (asynchronous) |
| pin_dsr | input | 1 | External data-set-ready level (asynchronous) |
| pin_ri | input | 1 | External ring-indicator level (asynchronous) |
| pin_dcd | input | 1 | External carrier-detect level (asynchronous) |
| mcr_dtr | input | 1 | Terminal-ready control output, looped to DSR |
| mcr_rts | input | 1 | Request-to-send control output, looped to CTS |
| mcr_out1 | input | 1 | User output 1, looped to RI |
| mcr_out2 | input | 1 | User output 2, looped to DCD |
| mcr_loop | input | 1 | Diagnostic loopback enable |
| ien_modem | input | 1 | Modem-status interrupt enable |
| rd_stb | input | 1 | CPU read strobe for the status byte |
| rd_data | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A change on an external pin is due in the level nibble after the second rising edge and in the flag nibble after the third. A looped control bit reaches its level bit in the same cycle and its flag after one edge. `irq` follows the flags without delay. The bench models the synchronizer stages and the edge compare cycle by cycle. It drives inputs one time unit after a rising edge and compares all outputs against the model at that point in every cycle. Directed checks sample on exactly the edge where a flag is first due, and also one edge earlier.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int unsigned NLINES = 4;

    // Internal status lines, bit order matches the level nibble of the byte
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } mlines_t;

    // Modem control outputs that feed the loopback path
    typedef struct packed {
        logic out2;
        logic out1;
        logic dtr;
        logic rts;
    } mctl_t;

    // Status byte as seen by the CPU
    typedef struct packed {
        mlines_t lvl;
        mlines_t chg;
    } mstat_t;

    // Route control outputs onto the status lines for diagnostics
    function automatic mlines_t loop_map(mctl_t c);
        mlines_t r;
        r.cts = c.rts;
        r.dsr = c.dtr;
        r.ri  = c.out1;
        r.dcd = c.out2;
        return r;
    endfunction

    // Per-line change detect: any edge, except RI which counts rising only
    function automatic mlines_t change_of(mlines_t now, mlines_t was);
        mlines_t d;
        d    = now ^ was;
        d.ri = now.ri & ~was.ri;
        return d;
    endfunction

endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mstat_src_sel.sv
module mstat_src_sel
    import mstat_pkg::*;
(
    input  logic    loop_en,
    input  mlines_t ext,
    input  mctl_t   ctl,
    output mlines_t lvl
);
    always_comb begin
        if (loop_en) lvl = loop_map(ctl);
        else         lvl = ext;
    end
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
    import mstat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mlines_t lvl,
    input  logic    rd_clr,
    output mlines_t flags,
    output mlines_t chg
);
    mlines_t prev_q;
    mlines_t flags_q;
    mlines_t kept;

    assign chg = change_of(lvl, prev_q);

    always_comb begin
        kept = rd_clr ? '0 : flags_q;
    end

    always_ff @(posedge clk) begin
        prev_q <= lvl;
        if (rst) flags_q <= '0;
        else     flags_q <= kept | chg;
    end

    assign flags = flags_q;
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
    import mstat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_cts,
    input  logic       pin_dsr,
    input  logic       pin_ri,
    input  logic       pin_dcd,
    input  logic       mcr_dtr,
    input  logic       mcr_rts,
    input  logic       mcr_out1,
    input  logic       mcr_out2,
    input  logic       mcr_loop,
    input  logic       ien_modem,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       irq
);
    mlines_t pin_vec;
    mlines_t pin_sync;
    mlines_t lvl;
    mlines_t flags;
    mlines_t chg;
    mctl_t   ctl;
    mstat_t  stat;

    assign pin_vec = '{dcd: pin_dcd, ri: pin_ri, dsr: pin_dsr, cts: pin_cts};
    assign ctl     = '{out2: mcr_out2, out1: mcr_out1, dtr: mcr_dtr, rts: mcr_rts};

    mstat_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (pin_vec),
        .q   (pin_sync)
    );

    mstat_src_sel u_sel (
        .loop_en (mcr_loop),
        .ext     (pin_sync),
        .ctl     (ctl),
        .lvl     (lvl)
    );

    mstat_delta u_dlt (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .rd_clr (rd_stb),
        .flags  (flags),
        .chg    (chg)
    );

    assign stat    = '{lvl: lvl, chg: flags};
    assign rd_data = stat;
    assign irq     = ien_modem & (|flags);
endmodule

// File: rtl/mstat_reg_chk.sv
module mstat_reg_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_stb,
    input logic       irq_en,
    input logic       loop_en,
    input logic [3:0] ctl_lvl,
    input logic [3:0] chg,
    input logic [7:0] rd_data,
    input logic       irq
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (rd_data[3:0] == 4'b0) && !irq);

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && chg == 4'b0) |=> rd_data[3:0] == 4'b0);

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0])));

    // R4
    ri_rise_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[2]) |-> $past(rd_data[6]));

    // R7
    loop_route_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> rd_data[7:4] == ctl_lvl);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_en && (rd_data[3:0] != 4'b0)));
endmodule

bind mstat_reg mstat_reg_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_stb  (rd_stb),
    .irq_en  (ien_modem),
    .loop_en (mcr_loop),
    .ctl_lvl ({mcr_out2, mcr_out1, mcr_dtr, mcr_rts}),
    .chg     (chg),
    .rd_data (rd_data),
    .irq     (irq)
);

// File: tb/mstat_reg_test.sv
`timescale 1ns/1ps
module mstat_reg_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_cts = 0, pin_dsr = 0, pin_ri = 0, pin_dcd = 0;
    logic mcr_dtr = 0, mcr_rts = 0, mcr_out1 = 0, mcr_out2 = 0;
    logic mcr_loop = 0, ien_modem = 0, rd_stb = 0;
    logic [7:0] rd_data;
    logic irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    bit chk_on = 0;

    // bench model: {dcd, ri, dsr, cts}
    logic [3:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_flg = 0;

    always #2.5 clk = ~clk;

    mstat_reg uut (
        .clk(clk), .rst(rst),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_dcd(pin_dcd),
        .mcr_dtr(mcr_dtr), .mcr_rts(mcr_rts), .mcr_out1(mcr_out1), .mcr_out2(mcr_out2),
        .mcr_loop(mcr_loop), .ien_modem(ien_modem), .rd_stb(rd_stb),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [3:0] exp_lines();
        if (mcr_loop) return {mcr_out2, mcr_out1, mcr_dtr, mcr_rts};
        return m_s2;
    endfunction

    function automatic logic [3:0] exp_change(logic [3:0] now, logic [3:0] was);
        logic [3:0] d;
        d    = now ^ was;
        d[2] = now[2] & ~was[2];
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [3:0] pre;
        pre = exp_lines();
        if (rst) m_flg = 4'b0;
        else     m_flg = (rd_stb ? 4'b0 : m_flg) | exp_change(pre, m_prev);
        m_prev = pre;
        m_s2   = m_s1;
        m_s1   = {pin_dcd, pin_ri, pin_dsr, pin_cts};
    endtask

    task automatic check_all();
        logic [3:0] el;
        el = exp_lines();
        chk(rd_data[7:4] == el, mcr_loop ? "R7 levels" : "R2 levels",
            {4'b0, rd_data[7:4]}, {4'b0, el});
        chk(rd_data[3:0] == m_flg, "R3 flags", {4'b0, rd_data[3:0]}, {4'b0, m_flg});
        chk(irq == (ien_modem && m_flg != 0), "R8 irq",
            {7'b0, irq}, {7'b0, ien_modem && m_flg != 0});
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_edge();
        if (chk_on) check_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_read();
        rd_stb = 1;
        tick();
        rd_stb = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c55));
        // R1: reset with some lines high
        pin_cts = 1; pin_dcd = 1;
        ticks(4);
        chk(rd_data[3:0] == 0 && !irq, "R1 flags in reset", rd_data, 8'h00);
        chk(rd_data[7:4] == 4'b1001, "R1 levels follow in reset", {4'b0, rd_data[7:4]}, 8'h09);
        chk_on = 1;
        tick();
        rst = 0;
        ticks(3);

        // R4: falling RI does not flag, rising does
        pin_ri = 1;
        ticks(4);
        do_read();
        pin_ri = 0;
        ticks(4);
        chk(rd_data[2] == 0, "R4 RI fall ignored", rd_data, {rd_data[7:3], 1'b0, rd_data[1:0]});
        pin_ri = 1;
        ticks(4);
        chk(rd_data[2] == 1, "R4 RI rise flagged", {7'b0, rd_data[2]}, 8'h01);

        // R9: flag stays until read
        ticks(10);
        chk(rd_data[2] == 1, "R9 sticky", {7'b0, rd_data[2]}, 8'h01);
        // R5: read shows pre-clear value, then clears
        rd_stb = 1;
        #1;
        chk(rd_data[2] == 1, "R5 read returns flag", {7'b0, rd_data[2]}, 8'h01);
        tick();
        rd_stb = 0;
        chk(rd_data[3:0] == 0, "R5 cleared after read", {4'b0, rd_data[3:0]}, 8'h00);

        // R2/R3: DSR latency, level at 2nd edge, flag at 3rd
        pin_dsr = 1;
        ticks(2);
        chk(rd_data[5] == 1 && rd_data[1] == 0, "R2 level due at edge 2",
            {6'b0, rd_data[5], rd_data[1]}, 8'h02);
        tick();
        chk(rd_data[1] == 1, "R3 DSR flag due at edge 3", {7'b0, rd_data[1]}, 8'h01);
        do_read();
        pin_dsr = 0;
        ticks(3);
        chk(rd_data[1] == 1, "R3 DSR falling flagged", {7'b0, rd_data[1]}, 8'h01);
        do_read();

        // R7: loopback routing, pins isolated
        mcr_loop = 1;
        tick();
        do_read();
        for (int i = 0; i < 6; i++) begin
            {pin_dcd, pin_ri, pin_dsr, pin_cts} = 4'($urandom);
            tick();
        end
        chk(rd_data == 8'h00, "R7 pins ignored in loopback", rd_data, 8'h00);
        mcr_rts = 1;
        #1;
        chk(rd_data[4] == 1, "R7 RTS drives CTS same cycle", {7'b0, rd_data[4]}, 8'h01);
        tick();
        do_read();
        // R6: change coinciding with read survives the clear
        rd_stb = 1;
        mcr_dtr = 1;
        tick();
        rd_stb = 0;
        chk(rd_data[3:0] == 4'b0010, "R6 change during read kept",
            {4'b0, rd_data[3:0]}, 8'h02);

        // R8: interrupt gating
        ien_modem = 0;
        #1;
        chk(irq == 0, "R8 irq masked", {7'b0, irq}, 8'h00);
        ien_modem = 1;
        #1;
        chk(irq == 1, "R8 irq raised", {7'b0, irq}, 8'h01);
        do_read();
        chk(irq == 0, "R8 irq drops after read", {7'b0, irq}, 8'h00);

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(3) == 0) {pin_dcd, pin_ri, pin_dsr, pin_cts} = 4'($urandom);
            if ($urandom_range(7) == 0) {mcr_out2, mcr_out1, mcr_dtr, mcr_rts} = 4'($urandom);
            if ($urandom_range(63) == 0) mcr_loop = ~mcr_loop;
            if ($urandom_range(31) == 0) ien_modem = ~ien_modem;
            rd_stb = ($urandom_range(4) == 0);
            tick();
        end
        rd_stb = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule